// File: doc/BRIEF.md
# Start/Done Handshake Controller for a Fixed-Latency Kernel

This block wraps a multi-cycle compute kernel in a block-level control handshake. An outside controller raises `start_i` to ask for work. The block answers with `ready_o` in the cycle it takes the two arguments, and `idle_o` drops on the next cycle. After a fixed number of cycles it raises `done_o` for one cycle. The result is on `ret_o` during that same cycle.

The kernel here is a stand-in iterative accumulator. On the cycle a request is accepted it loads `a + b`. It then adds `b` once per cycle, so the result is `a + LATENCY*b`. A controller that holds `start_i` high through the done cycle chains a new job with no idle gap. The return port is optional. When the parameter disables it, the port is tied to zero and has no register behind it.

Top module: `blk_hs_ctrl`

## Requirements
- R1: While `rst` is high (synchronous, active high), `idle_o`=1, `ready_o`=0 and `done_o`=0 whatever `start_i` does. From the first clock edge with `rst` high, `ret_o`=0.
- R2: A request is accepted in a cycle where `start_i`=1 and the block is either idle or in its done cycle. In that cycle `ready_o`=1 and both arguments are captured. `idle_o` is 0 from the next cycle.
- R3: Changes to `arg_a_i` or `arg_b_i` after the accept cycle have no effect on the result of the job in flight.
- R4: `done_o` is high in exactly one cycle per job. That cycle is exactly `LATENCY` cycles after the accept cycle.
- R5: In the done cycle, `ret_o` equals `(arg_a + LATENCY*arg_b) mod 2^DATA_W`, using the captured arguments.
- R6: `ret_o` changes only when it takes the new result for the done cycle. Between done cycles it holds its value, including while the next job runs.
- R7: If `start_i` is low in the done cycle, `idle_o` returns to 1 in the next cycle and `ready_o` stays 0.
- R8: If `start_i` is high in the done cycle, a new job is accepted in that cycle (`ready_o`=1) and `idle_o` stays 0.
- R9: `start_i` in a busy cycle other than the done cycle is ignored. `ready_o` stays 0 and the timing of the job in flight does not change.
- R10: With `HAS_RET`=0, `ret_o` is constant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a job |
| arg_a_i | input | DATA_W | First argument, captured on accept |
| arg_b_i | input | DATA_W | Second argument, captured on accept |
| ready_o | output | 1 | High in the cycle the arguments are taken |
| idle_o | output | 1 | Block holds no job |
| done_o | output | 1 | One-cycle completion pulse; result valid |
| ret_o | output | DATA_W | Return value, held between completions |

## Verification
The main instance uses `DATA_W`=16, `LATENCY`=5 and the return port enabled. A latency of 5 leaves room for several busy cycles in which stray `start_i` and changing arguments can be applied. Argument pairs near the top of the range make the sum wrap. A second instance uses `LATENCY`=1 and `HAS_RET`=0. With a latency of 1, accept and done fall in adjacent cycles, so back-to-back chaining gives a done pulse every cycle and exercises the tied-off return port.

// File: rtl/bhc_pkg.sv
`timescale 1ns/1ps
package bhc_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } bhc_state_e;

  // width of a counter that must reach n-1
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bhc_seq.sv
`timescale 1ns/1ps
module bhc_seq #(
  parameter int LATENCY = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic accept_o,
  output logic done_o,
  output logic idle_o,
  output logic advance_o,
  output logic last_step_o
);
  import bhc_pkg::*;

  localparam int CW = cnt_width(LATENCY);
  localparam logic [CW-1:0] LAST = CW'(LATENCY - 1);

  bhc_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          busy;
  logic          at_last;

  assign busy      = (state_q == ST_BUSY);
  assign at_last   = busy && (cnt_q == LAST);
  assign done_o    = !rst && at_last;
  assign idle_o    = rst || (state_q == ST_IDLE);
  assign accept_o  = !rst && start_i && ((state_q == ST_IDLE) || at_last);
  assign advance_o = !rst && busy && !at_last;

  generate
    if (LATENCY == 1) begin : g_lat1
      assign last_step_o = accept_o;
    end else begin : g_latn
      assign last_step_o = advance_o && (cnt_q == CW'(LATENCY - 2));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (accept_o) begin
      state_q <= ST_BUSY;
      cnt_q   <= '0;
    end else if (at_last) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (busy) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // R2
  accept_drops_idle_chk: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> !idle_o);

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !accept_o) |=> !done_o);

  // R7
  idle_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !accept_o) |=> idle_o);

  // R9
  busy_ignores_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!idle_o && !done_o) |-> !accept_o);

endmodule

// File: rtl/bhc_kernel.sv
`timescale 1ns/1ps
module bhc_kernel #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic              advance_i,
  input  logic [DATA_W-1:0] arg_a_i,
  input  logic [DATA_W-1:0] arg_b_i,
  output logic [DATA_W-1:0] acc_next_o
);

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] b_q;

  // one accumulation step, wraps modulo 2^DATA_W
  function automatic logic [DATA_W-1:0] kstep(input logic [DATA_W-1:0] x,
                                               input logic [DATA_W-1:0] y);
    return x + y;
  endfunction

  assign acc_next_o = accept_i ? kstep(arg_a_i, arg_b_i) : kstep(acc_q, b_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      b_q   <= '0;
    end else if (accept_i) begin
      acc_q <= acc_next_o;
      b_q   <= arg_b_i;
    end else if (advance_i) begin
      acc_q <= acc_next_o;
    end
  end

  // R3
  arg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !accept_i |=> $stable(b_q));

endmodule

// File: rtl/bhc_ret.sv
`timescale 1ns/1ps
module bhc_ret #(
  parameter int DATA_W  = 16,
  parameter bit HAS_RET = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] val_i,
  output logic [DATA_W-1:0] ret_o
);

  generate
    if (HAS_RET) begin : g_ret
      logic [DATA_W-1:0] ret_q;
      always_ff @(posedge clk) begin
        if (rst)         ret_q <= '0;
        else if (load_i) ret_q <= val_i;
      end
      assign ret_o = ret_q;

      // R6
      ret_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(ret_o));
    end else begin : g_noret
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst, load_i, val_i};
      assign ret_o = '0;

      // R10
      always_comb begin
        ret_tied_chk: assert (ret_o == '0);
      end
    end
  endgenerate

endmodule

// File: rtl/blk_hs_ctrl.sv
`timescale 1ns/1ps
module blk_hs_ctrl #(
  parameter int DATA_W  = 16,
  parameter int LATENCY = 5,
  parameter bit HAS_RET = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] arg_a_i,
  input  logic [DATA_W-1:0] arg_b_i,
  output logic              ready_o,
  output logic              idle_o,
  output logic              done_o,
  output logic [DATA_W-1:0] ret_o
);

  logic              accept;
  logic              advance;
  logic              last_step;
  logic [DATA_W-1:0] acc_next;

  bhc_seq #(.LATENCY(LATENCY)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .accept_o   (accept),
    .done_o     (done_o),
    .idle_o     (idle_o),
    .advance_o  (advance),
    .last_step_o(last_step)
  );

  bhc_kernel #(.DATA_W(DATA_W)) u_kernel (
    .clk       (clk),
    .rst       (rst),
    .accept_i  (accept),
    .advance_i (advance),
    .arg_a_i   (arg_a_i),
    .arg_b_i   (arg_b_i),
    .acc_next_o(acc_next)
  );

  bhc_ret #(.DATA_W(DATA_W), .HAS_RET(HAS_RET)) u_ret (
    .clk   (clk),
    .rst   (rst),
    .load_i(last_step),
    .val_i (acc_next),
    .ret_o (ret_o)
  );

  assign ready_o = accept;

  // R8
  chain_keeps_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && ready_o) |=> !idle_o);

  // R1
  always_comb begin
    if (rst) reset_quiet_chk: assert (idle_o && !ready_o && !done_o);
  end

endmodule

// File: tb/blk_hs_ctrl_bench.sv
`timescale 1ns/1ps
module blk_hs_ctrl_bench;

  localparam int W   = 16;
  localparam int LAT = 5;
  localparam int NV  = 8;

  // entry: {a[15:0], b[15:0], mode[1:0]}; mode 0 plain, 1 start held while busy, 2 chain into next
  localparam logic [33:0] VEC [0:NV-1] = '{
    {16'd3,      16'd4,      2'd0},
    {16'd0,      16'd0,      2'd0},
    {16'hFFFF,   16'hFFFF,   2'd1},
    {16'd100,    16'd1,      2'd2},
    {16'h8000,   16'h3000,   2'd2},
    {16'd7,      16'hFFFE,   2'd0},
    {16'h1234,   16'h0101,   2'd1},
    {16'd65530,  16'd2,      2'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] arg_a = '0, arg_b = '0;
  logic ready, idle, done;
  logic [W-1:0] ret;

  logic start2 = 1'b0;
  logic [W-1:0] arg_a2 = '0, arg_b2 = '0;
  logic ready2, idle2, done2;
  logic [W-1:0] ret2;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] prev_ret = '0;

  always #10 clk = ~clk;

  blk_hs_ctrl #(.DATA_W(W), .LATENCY(LAT), .HAS_RET(1'b1)) u_blk_hs_ctrl (
    .clk(clk), .rst(rst), .start_i(start), .arg_a_i(arg_a), .arg_b_i(arg_b),
    .ready_o(ready), .idle_o(idle), .done_o(done), .ret_o(ret));

  blk_hs_ctrl #(.DATA_W(W), .LATENCY(1), .HAS_RET(1'b0)) u_blk_hs_ctrl_lat1 (
    .clk(clk), .rst(rst), .start_i(start2), .arg_a_i(arg_a2), .arg_b_i(arg_b2),
    .ready_o(ready2), .idle_o(idle2), .done_o(done2), .ret_o(ret2));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [31:0] full;
    full = 32'(a) + 32'(b) * 32'(LAT);
    return full[W-1:0];
  endfunction

  // call just after a negedge with the block idle or in its done cycle
  task automatic txn(input logic [W-1:0] a, input logic [W-1:0] b, input bit busy_start);
    logic [W-1:0] exp;
    exp = model(a, b);
    start = 1'b1; arg_a = a; arg_b = b;
    #1 check(ready == 1'b1, "R2 ready on accept", ready, 1);
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      check(done == (k == LAT), "R4 done timing", done, (k == LAT));
      check(idle == 1'b0, "R2/R8 idle low while busy", idle, 0);
      if (k < LAT) begin
        check(ready == 1'b0, "R9 no accept while busy", ready, 0);
        check(ret == prev_ret, "R6 ret held", ret, prev_ret);
        arg_a = ~a ^ W'(k);
        arg_b = b + W'(7 * k);
        start = busy_start;
      end else begin
        check(ret == exp, "R5/R3 result", ret, exp);
        prev_ret = exp;
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    // R1: reset with noisy inputs
    start = 1'b1; arg_a = 16'h55; arg_b = 16'hAA;
    repeat (3) begin
      @(negedge clk);
      check(idle == 1'b1, "R1 idle in reset", idle, 1);
      check(ready == 1'b0, "R1 ready in reset", ready, 0);
      check(done == 1'b0, "R1 done in reset", done, 0);
      check(ret == '0, "R1 ret in reset", ret, 0);
    end
    rst = 1'b0; start = 1'b0;
    @(negedge clk);
    check(idle == 1'b1 && done == 1'b0, "R1 idle after reset", idle, 1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [1:0] m;
      m = VEC[i][1:0];
      txn(VEC[i][33:18], VEC[i][17:2], m == 2'd1);
      if (m != 2'd2) begin
        start = 1'b0;
        #1 check(ready == 1'b0, "R7 no accept", ready, 0);
        @(negedge clk);
        check(idle == 1'b1, "R7 idle returns", idle, 1);
        check(done == 1'b0, "R4 done one cycle", done, 0);
        check(ret == prev_ret, "R6 ret held after done", ret, prev_ret);
      end
    end

    // R1: reset in mid-job
    start = 1'b1; arg_a = 16'd9; arg_b = 16'd9;
    @(negedge clk); start = 1'b1;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(idle == 1'b1, "R1 idle mid-job reset", idle, 1);
    check(ready == 1'b0, "R1 ready mid-job reset", ready, 0);
    check(ret == '0, "R1 ret cleared", ret, 0);
    @(negedge clk);
    check(done == 1'b0, "R1 done in reset", done, 0);
    rst = 1'b0; start = 1'b0;
    @(negedge clk);
    check(idle == 1'b1, "R1 idle after release", idle, 1);
    prev_ret = '0;
    txn(16'd11, 16'd2, 1'b0);
    start = 1'b0;
    @(negedge clk);
    check(idle == 1'b1, "R7 idle after job", idle, 1);

    // LATENCY=1, no return port
    start2 = 1'b1; arg_a2 = 16'd5; arg_b2 = 16'd6;
    #1 check(ready2 == 1'b1, "R2 lat1 ready", ready2, 1);
    @(negedge clk);
    check(done2 == 1'b1, "R4 lat1 done next cycle", done2, 1);
    check(ret2 == '0, "R10 ret tied off", ret2, 0);
    check(idle2 == 1'b0, "R2 lat1 busy", idle2, 0);
    #1 check(ready2 == 1'b1, "R8 lat1 chain accept", ready2, 1);
    @(negedge clk);
    check(done2 == 1'b1 && idle2 == 1'b0, "R8 lat1 chained done", idle2, 0);
    check(ret2 == '0, "R10 ret tied off chained", ret2, 0);
    start2 = 1'b0;
    @(negedge clk);
    check(done2 == 1'b0, "R4 lat1 single", done2, 0);
    check(idle2 == 1'b1, "R7 lat1 idle", idle2, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule